// File: doc/BRIEF.md
# Vector Lane Bit Clear/Set/Flip Unit

This unit is one execution slot of a wide vector datapath. Each cycle it may accept one 32-bit instruction word together with two source vectors. It recognises a fixed family of 24 encodings. Each encoding clears, sets or inverts exactly one bit in every lane of the first source.

Lanes are 8, 16, 32 or 64 bits wide. The bit to touch comes from one of two places. In the register form it is the low bits of the matching lane of the second source, so each lane can name a different bit. In the immediate form a constant field in the instruction gives one bit index for all lanes.

The unit registers the resulting vector, the destination register index and an illegal-word flag. These appear one clock after the request. A word outside the family leaves the first source unchanged and raises the flag.

Top module: `vbitop_unit`

## Requirements
- R1: A clear operation produces, in every lane, the first-source lane with bit n forced to 0 and all other bits kept.
- R2: A set operation produces, in every lane, the first-source lane with bit n forced to 1 and all other bits kept.
- R3: An invert operation produces, in every lane, the first-source lane with bit n complemented and all other bits kept.
- R4: In the register form, n for lane i is the value of lane i of `vk` modulo the lane width. Lane bits above the low log2(width) bits have no effect on the result.
- R5: Lane widths are 8, 16, 32 and 64 bits, selected by size code 0, 1, 2 and 3. Lane i occupies bits [i*W+W-1 : i*W], and VLEN/W lanes are processed.
- R6: In the immediate form, one n applies to every lane. n is 3, 4, 5 or 6 bits wide for 8-, 16-, 32- or 64-bit lanes.
- R7: The register form matches insn[31:17] = 011101010000110 (clear), 011101010000111 (set) or 011101010001000 (invert). The size code is insn[16:15] and vk is named by insn[14:10].
- R8: The immediate form matches insn[31:20] = 011101110001, with op code insn[19:18] = 00 clear, 01 set, 10 invert, and insn[17] = 0. The size is set by the highest 1 among insn[16] (64-bit, n = insn[15:10]), insn[15] (32-bit, n = insn[14:10]), insn[14] (16-bit, n = insn[13:10]) and insn[13] (8-bit, n = insn[12:10]). If none of these bits is 1, the word is illegal.
- R9: For any other word, `illegal` is 1 and `result` equals `vj` unchanged.
- R10: `valid_out` equals `valid_in` of the previous clock. `result`, `vd_idx` and `illegal` describe the request accepted at that clock.
- R11: A synchronous active-high `rst` forces `valid_out` to 0 at the next clock edge.
- R12: `vd_idx` equals insn[4:0] of the accepted request, for both legal and illegal words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Request present this cycle |
| insn | input | 32 | Instruction word |
| vj | input | VLEN | First source vector |
| vk | input | VLEN | Second source vector (register-form bit indices) |
| valid_out | output | 1 | Result present |
| result | output | VLEN | Result vector |
| vd_idx | output | 5 | Destination register index |
| illegal | output | 1 | Word was not recognised |

## Verification
The bench builds the unit at its default VLEN of 256. At that width the 8-bit case has 32 lanes and the 64-bit case has 4 lanes, so the top lane of every width is exercised at the top end of the vector. At this width a behavioural model can also name every encoding, every immediate extreme and every near-miss word of the opcode map. The second source is filled with lanes whose upper bits are set, which shows the modulo rule. Requests arrive both back to back and with gaps.

// File: rtl/vbitop_unit.sv
`timescale 1ns/1ps
module vbitop_unit #(
  parameter int VLEN = 256
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            valid_in,
  input  logic [31:0]     insn,
  input  logic [VLEN-1:0] vj,
  input  logic [VLEN-1:0] vk,
  output logic            valid_out,
  output logic [VLEN-1:0] result,
  output logic [4:0]      vd_idx,
  output logic            illegal
);
  localparam logic [14:0] REG_CLR = 15'b011101010000110;
  localparam logic [14:0] REG_SET = 15'b011101010000111;
  localparam logic [14:0] REG_REV = 15'b011101010001000;
  localparam logic [11:0] IMM_PFX = 12'b011101110001;
  localparam logic [1:0]  OP_CLR = 2'd0;
  localparam logic [1:0]  OP_SET = 2'd1;
  localparam logic [1:0]  OP_REV = 2'd2;

  logic       legal, use_imm;
  logic [1:0] op, sz;
  logic [5:0] imm;
  logic [VLEN-1:0] lane_res [4];
  logic [VLEN-1:0] next_res;

  assign imm = insn[15:10];

  always_comb begin
    legal   = 1'b0;
    use_imm = 1'b0;
    op      = OP_CLR;
    sz      = insn[16:15];
    if (insn[31:17] == REG_CLR) begin
      legal = 1'b1;
      op    = OP_CLR;
    end else if (insn[31:17] == REG_SET) begin
      legal = 1'b1;
      op    = OP_SET;
    end else if (insn[31:17] == REG_REV) begin
      legal = 1'b1;
      op    = OP_REV;
    end else if (insn[31:20] == IMM_PFX && insn[19:18] != 2'b11 && !insn[17]) begin
      use_imm = 1'b1;
      op      = insn[19:18];
      legal   = 1'b1;
      if (insn[16])      sz = 2'd3;
      else if (insn[15]) sz = 2'd2;
      else if (insn[14]) sz = 2'd1;
      else if (insn[13]) sz = 2'd0;
      else               legal = 1'b0;
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_width
    localparam int W = 8 << g;
    localparam int N = VLEN / W;
    localparam logic [W-1:0] IDXM = W'(W - 1);
    localparam logic [W-1:0] ONE  = W'(1);
    logic [VLEN-1:0] r;
    for (genvar l = 0; l < N; l++) begin : g_lane
      logic [W-1:0] a, nsel, m;
      assign a    = vj[l*W +: W];
      assign nsel = use_imm ? W'(imm) : vk[l*W +: W];
      assign m    = ONE << (nsel & IDXM);
      assign r[l*W +: W] = (op == OP_CLR) ? (a & ~m) :
                           (op == OP_SET) ? (a | m) : (a ^ m);
    end
    assign lane_res[g] = r;
  end

  assign next_res = legal ? lane_res[sz] : vj;

  always_ff @(posedge clk) begin
    if (rst) valid_out <= 1'b0;
    else     valid_out <= valid_in;
    if (valid_in) begin
      result  <= next_res;
      vd_idx  <= insn[4:0];
      illegal <= !legal;
    end
  end
endmodule

module vbitop_unit_props #(
  parameter int VLEN = 256
) (
  input logic            clk,
  input logic            rst,
  input logic            valid_in,
  input logic [31:0]     insn,
  input logic [VLEN-1:0] vj,
  input logic            valid_out,
  input logic [VLEN-1:0] result,
  input logic [4:0]      vd_idx,
  input logic            illegal
);
  p_valid_follow_r10: assert property (@(posedge clk) disable iff (rst)
    valid_in |=> valid_out);
  p_valid_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> !valid_out);
  p_reset_clear_r11: assert property (@(posedge clk)
    rst |=> !valid_out);
  p_vd_index_r12: assert property (@(posedge clk) disable iff (rst)
    valid_in |=> vd_idx == $past(insn[4:0]));
  p_illegal_pass_r9: assert property (@(posedge clk) disable iff (rst)
    valid_in |=> (!illegal || result == $past(vj)));
  p_one_bit_per_lane_r5: assert property (@(posedge clk) disable iff (rst)
    valid_in |=> $countones(result ^ $past(vj)) <= VLEN / 8);
  p_set_only_raises_r2: assert property (@(posedge clk) disable iff (rst)
    (valid_in && insn[31:17] == 15'b011101010000111) |=> ((result & $past(vj)) == $past(vj)));
  p_clear_only_drops_r1: assert property (@(posedge clk) disable iff (rst)
    (valid_in && insn[31:17] == 15'b011101010000110) |=> ((result & ~$past(vj)) == '0));
endmodule

bind vbitop_unit vbitop_unit_props #(.VLEN(VLEN)) u_props (
  .clk(clk), .rst(rst), .valid_in(valid_in), .insn(insn), .vj(vj),
  .valid_out(valid_out), .result(result), .vd_idx(vd_idx), .illegal(illegal)
);

// File: tb/vbitop_unit_bench.sv
`timescale 1ns/1ps
module vbitop_unit_bench;
  localparam int VLEN = 256;

  logic clk = 0;
  logic rst = 1;
  logic valid_in = 0;
  logic [31:0] insn = '0;
  logic [VLEN-1:0] vj = '0, vk = '0;
  logic valid_out, illegal;
  logic [VLEN-1:0] result;
  logic [4:0] vd_idx;

  int checks = 0, errors = 0;

  typedef struct {
    logic v;
    logic [VLEN-1:0] res;
    logic [4:0] vd;
    logic bad;
    string tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  vbitop_unit #(.VLEN(VLEN)) u_vbitop_unit (
    .clk(clk), .rst(rst), .valid_in(valid_in), .insn(insn), .vj(vj), .vk(vk),
    .valid_out(valid_out), .result(result), .vd_idx(vd_idx), .illegal(illegal)
  );

  function automatic logic [VLEN-1:0] rnd();
    logic [VLEN-1:0] x;
    for (int i = 0; i < VLEN / 32; i++) x[i*32 +: 32] = $urandom;
    return x;
  endfunction

  // op: 0 clear, 1 set, 2 invert; sz: 0..3 = 8..64-bit lanes
  function automatic logic [31:0] enc(int op, int sz, bit immf, int n, int vd);
    logic [31:0] w;
    logic [1:0] o = 2'(op);
    w = $urandom;
    w[4:0] = 5'(vd);
    if (!immf) begin
      case (op)
        0: w[31:17] = 15'b011101010000110;
        1: w[31:17] = 15'b011101010000111;
        default: w[31:17] = 15'b011101010001000;
      endcase
      w[16:15] = 2'(sz);
    end else begin
      w[31:20] = 12'b011101110001;
      case (sz)
        0: w[19:10] = {o, 3'b000, 2'b01, 3'(n)};
        1: w[19:10] = {o, 3'b000, 1'b1, 4'(n)};
        2: w[19:10] = {o, 3'b001, 5'(n)};
        default: w[19:10] = {o, 2'b01, 6'(n)};
      endcase
    end
    return w;
  endfunction

  function automatic void model(input logic [31:0] w, input logic [VLEN-1:0] a, b,
                                output logic [VLEN-1:0] r, output logic bad,
                                output string tag);
    int op = -1, wb = 0, im = -1;
    casez (w[31:15])
      17'b011101010000110_??: op = 0;
      17'b011101010000111_??: op = 1;
      17'b011101010001000_??: op = 2;
      default: ;
    endcase
    if (op >= 0) wb = 8 << w[16:15];
    else casez (w[31:10])
      22'b011101110001_00000_01_???: begin op = 0; wb = 8;  im = int'(w[12:10]); end
      22'b011101110001_00000_1_????: begin op = 0; wb = 16; im = int'(w[13:10]); end
      22'b011101110001_00001_?????:  begin op = 0; wb = 32; im = int'(w[14:10]); end
      22'b011101110001_0001_??????:  begin op = 0; wb = 64; im = int'(w[15:10]); end
      22'b011101110001_01000_01_???: begin op = 1; wb = 8;  im = int'(w[12:10]); end
      22'b011101110001_01000_1_????: begin op = 1; wb = 16; im = int'(w[13:10]); end
      22'b011101110001_01001_?????:  begin op = 1; wb = 32; im = int'(w[14:10]); end
      22'b011101110001_0101_??????:  begin op = 1; wb = 64; im = int'(w[15:10]); end
      22'b011101110001_10000_01_???: begin op = 2; wb = 8;  im = int'(w[12:10]); end
      22'b011101110001_10000_1_????: begin op = 2; wb = 16; im = int'(w[13:10]); end
      22'b011101110001_10001_?????:  begin op = 2; wb = 32; im = int'(w[14:10]); end
      22'b011101110001_1001_??????:  begin op = 2; wb = 64; im = int'(w[15:10]); end
      default: ;
    endcase
    bad = (op < 0);
    r = a;
    if (bad) begin
      tag = "R9";
      return;
    end
    tag = $sformatf("R%0d R5 %s", op + 1, (im >= 0) ? "R6 R8" : "R4 R7");
    for (int i = 0; i < VLEN / wb; i++) begin
      int n = (im >= 0) ? im : (int'(b[i*wb +: 8]) % wb);
      case (op)
        0: r[i*wb + n] = 1'b0;
        1: r[i*wb + n] = 1'b1;
        default: r[i*wb + n] = ~a[i*wb + n];
      endcase
    end
  endfunction

  task automatic check_outputs();
    exp_t e;
    e = q.pop_front();
    checks++;
    if (valid_out !== e.v) begin
      errors++;
      $display("FAIL R10/R11 valid_out actual %b expected %b", valid_out, e.v);
    end
    if (e.v) begin
      checks++;
      if (result !== e.res) begin
        errors++;
        $display("FAIL %s result actual %h expected %h", e.tag, result, e.res);
      end
      checks++;
      if (vd_idx !== e.vd) begin
        errors++;
        $display("FAIL R12 vd_idx actual %0d expected %0d", vd_idx, e.vd);
      end
      checks++;
      if (illegal !== e.bad) begin
        errors++;
        $display("FAIL R9 illegal actual %b expected %b", illegal, e.bad);
      end
    end
  endtask

  task automatic step(bit v, logic [31:0] w, logic [VLEN-1:0] a, b, bit r = 0);
    exp_t e;
    @(negedge clk);
    check_outputs();
    rst = r; valid_in = v; insn = w; vj = a; vk = b;
    e.v = v && !r;
    model(w, a, b, e.res, e.bad, e.tag);
    e.vd = w[4:0];
    q.push_back(e);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    exp_t e0;
    logic [VLEN-1:0] ones_hi;
    e0.v = 0; e0.res = '0; e0.vd = '0; e0.bad = 0; e0.tag = "R11";
    // R11: reset holds valid_out low even with valid_in high
    q.push_back(e0);
    step(1, enc(1, 0, 0, 0, 3), rnd(), rnd(), 1);
    step(1, enc(1, 0, 0, 0, 3), rnd(), rnd(), 1);
    step(0, '0, '0, '0, 1);
    // R1 R2 R3 R5 R7: every op and size, register form, upper index bits random (R4)
    for (int op = 0; op < 3; op++)
      for (int sz = 0; sz < 4; sz++) begin
        step(1, enc(op, sz, 0, 0, op * 4 + sz), rnd(), rnd());
        step(1, enc(op, sz, 0, 0, 31), '0, rnd());
        step(1, enc(op, sz, 0, 0, 1), '1, rnd());
      end
    // R4: vk lanes all ones select the top bit of each lane
    for (int sz = 0; sz < 4; sz++) step(1, enc(0, sz, 0, 0, 7), '1, '1);
    ones_hi = '0;
    for (int i = 0; i < VLEN / 8; i++) ones_hi[i*8 +: 8] = 8'hF8 | 8'(i % 8);
    for (int sz = 0; sz < 4; sz++) step(1, enc(2, sz, 0, 0, 9), '0, ones_hi);
    // R6 R8: immediate form with index 0, max and random
    for (int op = 0; op < 3; op++)
      for (int sz = 0; sz < 4; sz++) begin
        step(1, enc(op, sz, 1, 0, 2), rnd(), '1);
        step(1, enc(op, sz, 1, (8 << sz) - 1, 4), rnd(), '0);
        step(1, enc(op, sz, 1, $urandom % (8 << sz), 6), rnd(), rnd());
      end
    // R9: near-miss words are illegal and pass vj through
    step(1, {15'b011101010001001, 17'h0ABCD}, rnd(), rnd());
    step(1, {12'b011101110001, 2'b11, 3'b000, 2'b01, 3'b101, 10'h3A5}, rnd(), rnd());
    step(1, {12'b011101110001, 2'b00, 1'b1, 17'h000F3}, rnd(), rnd());
    step(1, {12'b011101110001, 2'b01, 3'b000, 2'b00, 3'b111, 10'h155}, rnd(), rnd());
    step(1, 32'h00000000, rnd(), rnd());
    step(1, 32'hFFFFFFFF, rnd(), rnd());
    // R10: gaps between requests
    step(0, enc(1, 2, 0, 0, 5), rnd(), rnd());
    step(1, enc(1, 2, 0, 0, 5), rnd(), rnd());
    step(0, '0, '0, '0);
    // R11: reset in the middle of traffic
    step(1, enc(2, 3, 1, 17, 8), rnd(), rnd());
    step(1, enc(2, 3, 1, 17, 8), rnd(), rnd(), 1);
    step(1, enc(0, 1, 0, 0, 10), rnd(), rnd());
    // mixed random traffic
    for (int k = 0; k < 600; k++) begin
      logic [31:0] w;
      if ($urandom % 8 == 0) w = $urandom;
      else w = enc($urandom % 3, $urandom % 4, $urandom % 2, $urandom % 64, $urandom % 32);
      step($urandom % 4 != 0, w, rnd(), rnd());
    end
    step(0, '0, '0, '0);
    @(negedge clk);
    check_outputs();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule